// File: doc/BRIEF.md
# Analog Comparator Control and Interrupt Wrapper

This block is the digital side of a single analog voltage comparator inside a small microcontroller. Software programs one 8-bit control and status register over a byte-wide register bus. That register sets which pin feeds the comparator's positive input and which source feeds its negative input. It also turns the comparator on and decides whether the raw comparator result is routed to an output pin.

The raw comparator decision arrives as one asynchronous bit. The block brings it into the CPU clock domain through a two-flop synchronizer and exposes it as a read-only status bit. Any change of that status bit sets a sticky interrupt flag, which software clears by writing zero to it. An interrupt request leaves the block when the flag is set and the external interrupt enable is high.

After the comparator is switched on, its output needs time to settle. For a parameterized number of clock cycles, derived from the clock rate and a 10 µs settle time, the status bit is held at zero and the flag cannot be set. Turning the comparator off clears both the status bit and the flag.

Top module: `acmp_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Writes take effect only when the address equals REG_ADDR (default 0xAC). A read at any other address returns 0x00, and a write at any other address leaves the register unchanged.
- R2: Bits 7 and 6 always read as 0, and writing 1 to them has no effect.
- R3: Bit 5 (enable), bit 4 (positive select) and bit 3 (negative select) are read/write. Output `sel_pos` follows bit 4 (0 = pin A, 1 = pin B). Output `sel_neg` follows bit 3 (0 = external reference pin, 1 = internal reference).
- R4: `cmp_pin` equals `cmp_raw` with no clocking whenever bit 5 and bit 2 (output enable) are both 1. Otherwise `cmp_pin` is 0.
- R5: Bit 1 (status) holds `cmp_raw` after two synchronizer stages. A change of `cmp_raw` made before clock edge 1 shows in bit 1 after edge 3. Writes to bit 1 are ignored.
- R6: While bit 5 is 0, bits 1 and 0 read 0. A write that clears bit 5 also clears them at that same edge.
- R7: For SETTLE_CYC clock cycles after bit 5 goes from 0 to 1, bit 1 is held at 0 and the flag is not set. The first update of bit 1 is at edge SETTLE_CYC+1 after the enabling write.
- R8: Bit 0 (flag) is set at the same edge at which bit 1 changes value. This holds for both a 0→1 and a 1→0 change, including the first update after settling.
- R9: Writing 0 to bit 0 clears the flag. Writing 1 to bit 0 leaves it unchanged.
- R10: If a hardware set and a software clear of the flag fall on the same edge, the flag ends up 1.
- R11: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cmp_raw | input | 1 | Asynchronous result from the analog comparator |
| sel_pos | output | 1 | Positive input mux select |
| sel_neg | output | 1 | Negative input mux select |
| cmp_pin | output | 1 | Gated raw result to the output pin |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| irq | output | 1 | Interrupt request |

## Verification
The flag has two writers that can act on the same edge: the hardware set, which fires when the synchronized status bit changes, and the software clear, which is a write of 0 to bit 0. The bench changes `cmp_raw` and then places a clearing write in the cycle right before the edge at which the synchronizer delivers the change, so both act together. The flag must read 1 after that edge while the status bit shows the new value. A clear-wins design would leave the flag at 0.

// File: rtl/acmp_pkg.sv
// Package: acmp_pkg
// Shared constants for the comparator wrapper: register width and the bit
// positions of each control/status field. Software decodes these positions,
// so they are fixed; everything else is parameterized per instance.
package acmp_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_EN    = 5;
    localparam int BIT_PSEL  = 4;
    localparam int BIT_NSEL  = 3;
    localparam int BIT_OE    = 2;
    localparam int BIT_STAT  = 1;
    localparam int BIT_FLAG  = 0;
    localparam int CTRL_W    = BIT_EN + 1;   // bits used below the reserved pair
endpackage

// File: rtl/acmp_sync.sv
// Module: acmp_sync
// Multi-stage synchronizer that moves an asynchronous bit into the clk domain.
// Assumes the input may change at any time; the output is the last stage.
module acmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[g] <= 1'b0;
                else if (g == 0)
                    chain_q[g] <= din;
                else
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/acmp_settle.sv
// Module: acmp_settle
// Settle-time blanking counter. Starts counting when the enable becomes 1.
// busy stays high for CYCLES clock cycles and then drops until the enable
// goes back to 0, which rewinds the counter for the next enable.
module acmp_settle #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count up while enabled until the settle window is spent; rewind when off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign busy = en && (cnt_q != LAST);
endmodule

// File: rtl/acmp_csr.sv
// Module: acmp_csr
// Control/status register core: holds the configuration bits, the
// synchronized status bit and the sticky change flag. Assumes wr is a
// one-cycle strobe already qualified by the address decode, and that sync_res
// is already in the clk domain. A hardware set beats a software clear.
module acmp_csr
    import acmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              sync_res,
    input  logic              busy,
    output logic              en,
    output logic              psel,
    output logic              nsel,
    output logic              oe,
    output logic              status,
    output logic              flag,
    output logic              en_next,
    output logic              flag_set
);
    logic live;

    // Enable as it will be after this edge; a disabling write clears at once.
    assign en_next  = wr ? wdata[BIT_EN] : en;
    // Status may follow the synchronizer only when enabled and settled.
    assign live     = en && !busy;
    assign flag_set = live && (sync_res != status);

    // Configuration bits: plain software read/write fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            psel <= 1'b0;
            nsel <= 1'b0;
            oe   <= 1'b0;
        end else if (wr) begin
            en   <= wdata[BIT_EN];
            psel <= wdata[BIT_PSEL];
            nsel <= wdata[BIT_NSEL];
            oe   <= wdata[BIT_OE];
        end
    end

    // Status bit: synchronized result, zero while disabled or settling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= 1'b0;
        else if (!en_next || !live)
            status <= 1'b0;
        else
            status <= sync_res;
    end

    // Change flag: set on status change, software clear by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (!en_next)
            flag <= 1'b0;
        else if (flag_set)
            flag <= 1'b1;
        else if (wr && !wdata[BIT_FLAG])
            flag <= 1'b0;
    end
endmodule

// File: rtl/acmp_ctrl.sv
// Module: acmp_ctrl (top)
// Digital wrapper for one analog comparator: register bus decode, input mux
// selects, gated raw pin output, clock-domain synchronization, settle
// blanking and the change interrupt. Assumes cmp_raw is fully asynchronous
// and that the bus presents one write strobe per access.
module acmp_ctrl
    import acmp_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  REG_ADDR  = 8'hAC,
    parameter int          CLK_MHZ   = 50,
    parameter int          SETTLE_US = 10,
    parameter int          SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cmp_raw,
    output logic              sel_pos,
    output logic              sel_neg,
    output logic              cmp_pin,
    input  logic              irq_en,
    output logic              irq
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    logic hit, wr, sync_res, busy;
    logic en, psel, nsel, oe, status, flag, en_next, flag_set;

    assign hit = (bus_addr == ADDR_W'(REG_ADDR));
    assign wr  = hit && bus_we;

    acmp_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw),
        .dout  (sync_res)
    );

    acmp_settle #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .busy  (busy)
    );

    acmp_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .wdata    (bus_wdata[CTRL_W-1:0]),
        .sync_res (sync_res),
        .busy     (busy),
        .en       (en),
        .psel     (psel),
        .nsel     (nsel),
        .oe       (oe),
        .status   (status),
        .flag     (flag),
        .en_next  (en_next),
        .flag_set (flag_set)
    );

    // Read mux: register image at the decoded address, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_EN]   = en;
            bus_rdata[BIT_PSEL] = psel;
            bus_rdata[BIT_NSEL] = nsel;
            bus_rdata[BIT_OE]   = oe;
            bus_rdata[BIT_STAT] = status;
            bus_rdata[BIT_FLAG] = flag;
        end
    end

    assign sel_pos = psel;
    assign sel_neg = nsel;
    assign cmp_pin = cmp_raw && en && oe;
    assign irq     = flag && irq_en;
endmodule

// File: rtl/acmp_ctrl_sva.sv
// Module: acmp_ctrl_sva
// Property checker bound into acmp_ctrl; observes ports and CSR state.
module acmp_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_rdata,
    input logic       cmp_raw,
    input logic       cmp_pin,
    input logic       irq,
    input logic       irq_en,
    input logic       en,
    input logic       en_next,
    input logic       status,
    input logic       flag,
    input logic       flag_set,
    input logic       busy
);
    // R2: reserved bits never read as 1.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);

    // R4: the pin never shows a 1 the comparator did not produce.
    a_r4_pin_from_raw: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pin |-> (cmp_raw && en));

    // R6: disabled comparator has neither status nor flag.
    a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!status && !flag));

    // R7: status stays 0 throughout the settle window.
    a_r7_blank_status: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !status);

    // R10: a hardware set always lands, whatever software writes.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && en_next) |=> flag);

    // R11: request needs the external enable.
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && flag));
endmodule

bind acmp_ctrl acmp_ctrl_sva u_acmp_ctrl_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rdata (bus_rdata),
    .cmp_raw   (cmp_raw),
    .cmp_pin   (cmp_pin),
    .irq       (irq),
    .irq_en    (irq_en),
    .en        (en),
    .en_next   (en_next),
    .status    (status),
    .flag      (flag),
    .flag_set  (flag_set),
    .busy      (busy)
);

// File: tb/acmp_ctrl_bench.sv
// Bench: acmp_ctrl_bench
// Directed scenarios, one task each; inputs driven at the falling edge,
// outputs sampled there too.
module acmp_ctrl_bench;
    localparam logic [7:0] REG = 8'hAC;
    localparam int SETTLE = 500;   // 50 MHz x 10 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = REG;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_raw = 1'b0;
    logic       sel_pos, sel_neg, cmp_pin, irq;
    logic       irq_en = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    acmp_ctrl u_acmp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
        .sel_pos(sel_pos), .sel_neg(sel_neg), .cmp_pin(cmp_pin),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a falling edge; one-cycle write, returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_addr = REG;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = REG;
    endtask

    task automatic t_reset_decode;
        logic [7:0] d;
        rd(REG, d);               chk("R1 reset value", d, 8'h00);
        wr(8'hAD, 8'h3C);
        rd(REG, d);               chk("R1 foreign write ignored", d, 8'h00);
        rd(8'hAD, d);             chk("R1 foreign read zero", d, 8'h00);
    endtask

    task automatic t_fields;
        logic [7:0] d;
        wr(REG, 8'hFF);
        rd(REG, d);               chk("R2 R3 R5 R9 write FF readback", d, 8'h3C);
        chk("R3 sel_pos", {7'd0, sel_pos}, 8'h01);
        chk("R3 sel_neg", {7'd0, sel_neg}, 8'h01);
        wr(REG, 8'h08);
        chk("R3 sel_pos low", {7'd0, sel_pos}, 8'h00);
        chk("R3 sel_neg high", {7'd0, sel_neg}, 8'h01);
        wr(REG, 8'h00);
    endtask

    task automatic t_pin;
        wr(REG, 8'h24);
        cmp_raw = 1'b1; #1;       chk("R4 pin follows raw 1", {7'd0, cmp_pin}, 8'h01);
        cmp_raw = 1'b0; #1;       chk("R4 pin follows raw 0", {7'd0, cmp_pin}, 8'h00);
        cmp_raw = 1'b1;
        wr(REG, 8'h20); #1;       chk("R4 pin off without oe", {7'd0, cmp_pin}, 8'h00);
        wr(REG, 8'h04); #1;       chk("R4 pin off without enable", {7'd0, cmp_pin}, 8'h00);
        wr(REG, 8'h00);
    endtask

    // cmp_raw already 1 for several cycles; enable and watch the blanking.
    task automatic t_settle;
        logic [7:0] d;
        cmp_raw = 1'b1;
        repeat (3) @(negedge clk);
        wr(REG, 8'h20);
        repeat (SETTLE - 1) @(posedge clk);
        @(negedge clk);
        rd(REG, d);               chk("R7 blank late", d, 8'h20);
        @(negedge clk);
        rd(REG, d);               chk("R7 blank last cycle", d, 8'h20);
        @(negedge clk);
        rd(REG, d);               chk("R7 R8 first update sets flag", d, 8'h23);
    endtask

    task automatic t_flag_sw;
        logic [7:0] d;
        wr(REG, 8'h21);
        rd(REG, d);               chk("R9 write 1 keeps flag", d, 8'h23);
        irq_en = 1'b1; #1;        chk("R11 irq on", {7'd0, irq}, 8'h01);
        irq_en = 1'b0; #1;        chk("R11 irq masked", {7'd0, irq}, 8'h00);
        wr(REG, 8'h20);
        rd(REG, d);               chk("R9 write 0 clears flag", d, 8'h22);
        irq_en = 1'b1; #1;        chk("R11 irq off with flag clear", {7'd0, irq}, 8'h00);
        irq_en = 1'b0;
    endtask

    task automatic t_latency_fall;
        logic [7:0] d;
        cmp_raw = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(REG, d);               chk("R5 not yet after two edges", d, 8'h22);
        @(negedge clk);
        rd(REG, d);               chk("R5 R8 fall after three edges", d, 8'h21);
        wr(REG, 8'h20);
    endtask

    task automatic t_collision;
        logic [7:0] d;
        cmp_raw = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(REG, 8'h20);           // clear lands on the same edge as the set
        rd(REG, d);               chk("R10 set beats clear", d, 8'h23);
    endtask

    task automatic t_disable;
        logic [7:0] d;
        wr(REG, 8'h02);
        rd(REG, d);               chk("R6 disable clears status and flag", d, 8'h00);
        cmp_raw = 1'b0;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        rd(REG, d);               chk("R6 no flag while off", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_decode();
        t_fields();
        t_pin();
        t_settle();
        t_flag_sw();
        t_latency_fall();
        t_collision();
        t_disable();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule